// File: doc/BRIEF.md
# Memory Access Ordering Queue

This block sits between an out-of-order core and data memory and keeps pending loads and stores in two separate circular queues, each in program order. Every access that enters is younger than everything already held in either queue, so the block can tell, at the moment an access arrives, which pending entries it has to respect. A load compares its address with every pending store. If the address matches, the load takes the data of the youngest matching store and never reads memory. A store remembers which loads were ahead of it. It is not written to memory while one of those loads still targets the same address. Stores reach memory in arrival order, so two writes to one address land in the right sequence.

One shared memory port carries one read or one write per cycle. Load results, whether read from memory or forwarded, leave through a return port in load program order, together with the tag the core gave the load. A flush input empties both queues in a single cycle. The queue depth, the address, data and tag widths are parameters, and the depth must be a power of two.

Top module: `lsq_order_unit`

## Requirements
- R1: After reset, `ld_full`, `st_full`, `mem_req_valid` and `ret_valid` are all low.
- R2: Each queue holds `DEPTH` entries and raises its full flag when it holds that many. An enqueue offered while full is dropped: a dropped load never returns, and every accepted load returns exactly once.
- R3: A load whose address equals that of a pending store returns that store's data with `ret_fwd` = 1 and issues no memory read. A store enqueued in the same cycle as the load counts as older than the load. With an empty load queue, the result appears one cycle after the enqueue edge.
- R4: When several pending stores match a load's address, the youngest of them supplies the forwarded data.
- R5: A load with no matching store reads memory. The read request (`mem_req_we` = 0) is visible one cycle after the load enters an empty queue. The result leaves with `ret_fwd` = 0 one cycle after `mem_rsp_valid`, three cycles after the enqueue edge. At most one load read is outstanding at a time.
- R6: Load results leave in load program order, carrying the tag given at enqueue.
- R7: A store whose address matches an older pending load is not written to memory until that load has returned its result. The load observes the memory value from before the store.
- R8: Stores write memory (`mem_req_we` = 1) only from the store queue head, one per cycle, in arrival order. After two stores to one address, memory holds the younger store's data.
- R9: When a load and a store are both ready to use the memory port in the same cycle, the load goes first and the store follows in the next cycle.
- R10: A one-cycle `flush` empties both queues. In the next cycle both full flags, `mem_req_valid` and `ret_valid` are low. Flushed entries produce no later return or write, and a memory response still in flight is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears both queues |
| ld_enq_valid | input | 1 | Load enqueue request |
| ld_enq_addr | input | ADDR_W | Load address |
| ld_enq_tag | input | TAG_W | Core tag returned with the result |
| ld_full | output | 1 | Load queue full, enqueue dropped |
| st_enq_valid | input | 1 | Store enqueue request |
| st_enq_addr | input | ADDR_W | Store address |
| st_enq_data | input | DATA_W | Store data |
| st_full | output | 1 | Store queue full, enqueue dropped |
| mem_req_valid | output | 1 | Memory request (registered) |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data |
| ret_valid | output | 1 | Load result valid (registered) |
| ret_tag | output | TAG_W | Tag of the returning load |
| ret_data | output | DATA_W | Load result |
| ret_fwd | output | 1 | 1 = result forwarded from a store |

## Verification
Every result of this block has a fixed distance from its cause. Counting from the edge that accepts the access, a forwarded load is due one cycle later. A memory read request is due one cycle later and the read result three cycles later. A store that is not blocked writes one cycle after it is accepted, or two when a load takes the port first. A store blocked by a matching load writes one cycle after that load's result appears. The bench records the cycle number of every request and return it sees on the falling edge, and compares each against the edge number of its enqueue. The due cycle is worked out from these counts, so a result that comes early or late fails even when its value is right.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  // Kind of operation presented on the shared memory port.
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_READ  = 2'd1,
    PORT_WRITE = 2'd2
  } port_op_e;
endpackage

// File: rtl/lsq_youngest_match.sv
// Scans a circular buffer from its oldest slot and reports the last
// (youngest) slot whose hit bit is set.
module lsq_youngest_match #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hits,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    logic [IDX_W-1:0] k;
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      k = start + IDX_W'(i);
      if (hits[k]) begin
        found = 1'b1;
        idx   = k;
      end
    end
  end
endmodule

// File: rtl/lsq_store_queue.sv
// Store side: program-ordered circular buffer, forwarding lookup and
// per-entry record of the older loads that can block the write.
module lsq_store_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          push,
  input  logic [ADDR_W-1:0]             push_addr,
  input  logic [DATA_W-1:0]             push_data,
  input  logic [DEPTH-1:0]              push_older,
  input  logic [DEPTH-1:0]              ld_retire,
  input  logic [DEPTH-1:0]              ld_valid,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  ld_addr,
  input  logic                          pop,
  input  logic [ADDR_W-1:0]             look_addr,
  output logic                          full,
  output logic                          head_ready,
  output logic [ADDR_W-1:0]             head_addr,
  output logic [DATA_W-1:0]             head_data,
  output logic                          fwd_hit,
  output logic [DATA_W-1:0]             fwd_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] CNT_FULL = (PTR_W+1)'(DEPTH);

  logic [DEPTH-1:0]   valid_q;
  logic [ADDR_W-1:0]  addr_q   [DEPTH];
  logic [DATA_W-1:0]  data_mem [DEPTH];
  logic [DEPTH-1:0]   older_q  [DEPTH];
  logic [PTR_W-1:0]   head_q, tail_q;
  logic [PTR_W:0]     cnt_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else begin
      // A retiring load slot may be reused by a younger load: forget it.
      for (int i = 0; i < DEPTH; i++) older_q[i] <= older_q[i] & ~ld_retire;
      if (push) begin
        valid_q[tail_q] <= 1'b1;
        older_q[tail_q] <= push_older;
        tail_q          <= tail_q + 1'b1;
      end
      if (pop) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= head_q + 1'b1;
      end
      cnt_q <= cnt_q + {{PTR_W{1'b0}}, push} - {{PTR_W{1'b0}}, pop};
    end
  end

  // Payload storage, no reset, single write port at the tail.
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q]   <= push_addr;
      data_mem[tail_q] <= push_data;
    end
  end

  assign full      = (cnt_q == CNT_FULL);
  assign head_addr = addr_q[head_q];
  assign head_data = data_mem[head_q];

  // Write-after-read guard: an older load to the same address blocks the head.
  logic [DEPTH-1:0] war_block;
  always_comb begin
    for (int j = 0; j < DEPTH; j++)
      war_block[j] = older_q[head_q][j] & ld_valid[j] & (ld_addr[j] == addr_q[head_q]);
  end
  assign head_ready = valid_q[head_q] & ~(|war_block);

  // Read-after-write forwarding lookup.
  logic [DEPTH-1:0] look_hits;
  logic [PTR_W-1:0] fwd_idx;
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      look_hits[i] = valid_q[i] & (addr_q[i] == look_addr);
  end

  lsq_youngest_match #(.N(DEPTH), .IDX_W(PTR_W)) u_pick (
    .hits  (look_hits),
    .start (head_q),
    .found (fwd_hit),
    .idx   (fwd_idx)
  );
  assign fwd_data = data_mem[fwd_idx];

  AST_ST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q < CNT_FULL)); // R2
  AST_WAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    pop |-> head_ready); // R7
endmodule

// File: rtl/lsq_load_queue.sv
// Load side: program-ordered circular buffer. Each entry carries its tag
// and, when the data was forwarded at enqueue, the forwarded value.
module lsq_load_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          push,
  input  logic [ADDR_W-1:0]             push_addr,
  input  logic [TAG_W-1:0]              push_tag,
  input  logic                          push_fwd,
  input  logic [DATA_W-1:0]             push_fwd_data,
  input  logic                          pop,
  output logic                          full,
  output logic [DEPTH-1:0]              valid_vec,
  output logic [DEPTH-1:0][ADDR_W-1:0]  addr_vec,
  output logic [$clog2(DEPTH)-1:0]      head_idx,
  output logic                          head_valid,
  output logic [ADDR_W-1:0]             head_addr,
  output logic [TAG_W-1:0]              head_tag,
  output logic                          head_fwd,
  output logic [DATA_W-1:0]             head_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] CNT_FULL = (PTR_W+1)'(DEPTH);

  logic [DEPTH-1:0]              valid_q;
  logic [DEPTH-1:0][ADDR_W-1:0]  addr_q;
  logic [DEPTH-1:0]              fwd_q;
  logic [TAG_W-1:0]              tag_mem  [DEPTH];
  logic [DATA_W-1:0]             fdat_mem [DEPTH];
  logic [PTR_W-1:0]              head_q, tail_q;
  logic [PTR_W:0]                cnt_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (push) begin
        valid_q[tail_q] <= 1'b1;
        tail_q          <= tail_q + 1'b1;
      end
      if (pop) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= head_q + 1'b1;
      end
      cnt_q <= cnt_q + {{PTR_W{1'b0}}, push} - {{PTR_W{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q]   <= push_addr;
      fwd_q[tail_q]    <= push_fwd;
      tag_mem[tail_q]  <= push_tag;
      fdat_mem[tail_q] <= push_fwd_data;
    end
  end

  assign full       = (cnt_q == CNT_FULL);
  assign valid_vec  = valid_q;
  assign addr_vec   = addr_q;
  assign head_idx   = head_q;
  assign head_valid = valid_q[head_q];
  assign head_addr  = addr_q[head_q];
  assign head_tag   = tag_mem[head_q];
  assign head_fwd   = fwd_q[head_q];
  assign head_data  = fdat_mem[head_q];

  AST_LD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q < CNT_FULL)); // R2
  AST_LD_POP_HEAD: assert property (@(posedge clk) disable iff (rst)
    pop |-> valid_q[head_q]); // R6
endmodule

// File: rtl/lsq_order_unit.sv
// Memory access ordering queue: load and store queues, shared memory
// port arbitration and the load return path.
module lsq_order_unit #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              ld_enq_valid,
  input  logic [ADDR_W-1:0] ld_enq_addr,
  input  logic [TAG_W-1:0]  ld_enq_tag,
  output logic              ld_full,
  input  logic              st_enq_valid,
  input  logic [ADDR_W-1:0] st_enq_addr,
  input  logic [DATA_W-1:0] st_enq_data,
  output logic              st_full,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [DATA_W-1:0] ret_data,
  output logic              ret_fwd
);
  import lsq_pkg::*;
  localparam int PTR_W = $clog2(DEPTH);

  logic ld_push, st_push;
  assign ld_push = ld_enq_valid & ~ld_full & ~flush;
  assign st_push = st_enq_valid & ~st_full & ~flush;

  // Load queue signals
  logic [DEPTH-1:0]              ld_valid_vec;
  logic [DEPTH-1:0][ADDR_W-1:0]  ld_addr_vec;
  logic [PTR_W-1:0]              ld_head_idx;
  logic                          ld_head_valid, ld_head_fwd;
  logic [ADDR_W-1:0]             ld_head_addr;
  logic [TAG_W-1:0]              ld_head_tag;
  logic [DATA_W-1:0]             ld_head_data;
  logic                          ld_pop;

  // Store queue signals
  logic              st_head_ready, st_fwd_hit;
  logic [ADDR_W-1:0] st_head_addr;
  logic [DATA_W-1:0] st_head_data, st_fwd_data;
  logic              st_issue;

  // Forwarding: a store entering in the same cycle is older than the load.
  logic              same_cyc_hit, ld_fwd;
  logic [DATA_W-1:0] ld_fwd_data;
  assign same_cyc_hit = st_push & (st_enq_addr == ld_enq_addr);
  assign ld_fwd       = same_cyc_hit | st_fwd_hit;
  assign ld_fwd_data  = same_cyc_hit ? st_enq_data : st_fwd_data;

  // Load head sequencing: one memory read in flight at a time.
  logic ld_busy_q, ld_issue, ld_fwd_ret, ld_rsp_take;
  assign ld_issue    = ld_head_valid & ~ld_head_fwd & ~ld_busy_q;
  assign ld_fwd_ret  = ld_head_valid &  ld_head_fwd & ~ld_busy_q;
  assign ld_rsp_take = ld_busy_q & mem_rsp_valid;
  assign ld_pop      = (ld_fwd_ret | ld_rsp_take) & ~flush;

  logic [DEPTH-1:0] ld_retire, st_older;
  assign ld_retire = ld_pop ? (DEPTH'(1) << ld_head_idx) : '0;
  assign st_older  = ld_valid_vec & ~ld_retire;

  // Port arbitration: loads first.
  port_op_e port_op;
  always_comb begin
    if (ld_issue)           port_op = PORT_READ;
    else if (st_head_ready) port_op = PORT_WRITE;
    else                    port_op = PORT_IDLE;
  end
  assign st_issue = (port_op == PORT_WRITE) & ~flush;

  always_ff @(posedge clk) begin
    if (rst || flush) ld_busy_q <= 1'b0;
    else if (ld_issue)    ld_busy_q <= 1'b1;
    else if (ld_rsp_take) ld_busy_q <= 1'b0;
  end

  // Registered memory request.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
    end else begin
      mem_req_valid <= (port_op != PORT_IDLE);
      mem_req_we    <= (port_op == PORT_WRITE);
    end
  end
  always_ff @(posedge clk) begin
    mem_req_addr  <= (port_op == PORT_WRITE) ? st_head_addr : ld_head_addr;
    mem_req_wdata <= st_head_data;
  end

  // Registered load return.
  always_ff @(posedge clk) begin
    if (rst || flush) ret_valid <= 1'b0;
    else              ret_valid <= ld_pop;
  end
  always_ff @(posedge clk) begin
    if (ld_pop) begin
      ret_tag  <= ld_head_tag;
      ret_fwd  <= ld_fwd_ret;
      ret_data <= ld_fwd_ret ? ld_head_data : mem_rsp_data;
    end
  end

  lsq_load_queue #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_ldq (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .push          (ld_push),
    .push_addr     (ld_enq_addr),
    .push_tag      (ld_enq_tag),
    .push_fwd      (ld_fwd),
    .push_fwd_data (ld_fwd_data),
    .pop           (ld_pop),
    .full          (ld_full),
    .valid_vec     (ld_valid_vec),
    .addr_vec      (ld_addr_vec),
    .head_idx      (ld_head_idx),
    .head_valid    (ld_head_valid),
    .head_addr     (ld_head_addr),
    .head_tag      (ld_head_tag),
    .head_fwd      (ld_head_fwd),
    .head_data     (ld_head_data)
  );

  lsq_store_queue #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_stq (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .push       (st_push),
    .push_addr  (st_enq_addr),
    .push_data  (st_enq_data),
    .push_older (st_older),
    .ld_retire  (ld_retire),
    .ld_valid   (ld_valid_vec),
    .ld_addr    (ld_addr_vec),
    .pop        (st_issue),
    .look_addr  (ld_enq_addr),
    .full       (st_full),
    .head_ready (st_head_ready),
    .head_addr  (st_head_addr),
    .head_data  (st_head_data),
    .fwd_hit    (st_fwd_hit),
    .fwd_data   (st_fwd_data)
  );

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!ld_full && !st_full && !mem_req_valid && !ret_valid)); // R10
  AST_RET_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !ret_fwd) |-> $past(mem_rsp_valid)); // R5
  AST_ONE_READ_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_we) |=> !(mem_req_valid && !mem_req_we)); // R5
  AST_FWD_NO_PORT: assert property (@(posedge clk) disable iff (rst)
    (ld_fwd_ret && !st_head_ready) |=> !mem_req_valid); // R3
endmodule

// File: tb/lsq_order_unit_bench.sv
`timescale 1ns/1ps
module lsq_order_unit_bench;
  localparam int AW = 16, DW = 32, TW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic ld_enq_valid = 1'b0, st_enq_valid = 1'b0;
  logic [AW-1:0] ld_enq_addr = '0, st_enq_addr = '0;
  logic [TW-1:0] ld_enq_tag = '0;
  logic [DW-1:0] st_enq_data = '0;
  logic ld_full, st_full, mem_req_valid, mem_req_we, ret_valid, ret_fwd;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata, ret_data;
  logic [TW-1:0] ret_tag;
  logic mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;

  always #2.5 clk = ~clk;

  lsq_order_unit #(.DEPTH(8), .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW)) u_lsq_order_unit (
    .clk(clk), .rst(rst), .flush(flush),
    .ld_enq_valid(ld_enq_valid), .ld_enq_addr(ld_enq_addr), .ld_enq_tag(ld_enq_tag), .ld_full(ld_full),
    .st_enq_valid(st_enq_valid), .st_enq_addr(st_enq_addr), .st_enq_data(st_enq_data), .st_full(st_full),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data), .ret_fwd(ret_fwd)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hA500_0000 | (a & 8'hFF);
  endfunction

  // Memory model: one-cycle synchronous read.
  logic [DW-1:0] mem [256];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      mem_rsp_valid <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_we) mem[mem_req_addr[7:0]] <= mem_req_wdata;
      mem_rsp_valid <= mem_req_valid && !mem_req_we;
      mem_rsp_data  <= mem[mem_req_addr[7:0]];
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Event logs sampled on the falling edge.
  int rn = 0, mn = 0;
  logic [TW-1:0] r_tag [64];
  logic [DW-1:0] r_dat [64];
  logic          r_fwd [64];
  int            r_cyc [64];
  logic          m_we  [64];
  logic [AW-1:0] m_adr [64];
  logic [DW-1:0] m_dat [64];
  int            m_cyc [64];
  always @(negedge clk) begin
    if (ret_valid && rn < 64) begin
      r_tag[rn] = ret_tag; r_dat[rn] = ret_data; r_fwd[rn] = ret_fwd; r_cyc[rn] = cyc; rn++;
    end
    if (mem_req_valid && mn < 64) begin
      m_we[mn] = mem_req_we; m_adr[mn] = mem_req_addr; m_dat[mn] = mem_req_wdata; m_cyc[mn] = cyc; mn++;
    end
  end

  int n_checks = 0, n_fail = 0;
  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk); rn = 0; mn = 0;
  endtask
  task automatic idle();
    ld_enq_valid = 0; st_enq_valid = 0; flush = 0;
  endtask
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "ld_full", ld_full, 0);
    chk("R1", "st_full", st_full, 0);
    chk("R1", "mem_req_valid", mem_req_valid, 0);
    chk("R1", "ret_valid", ret_valid, 0);
  endtask

  task automatic t_mem_load(); // R5
    int e;
    clear_logs();
    ld_enq_valid = 1; ld_enq_addr = 16'h0010; ld_enq_tag = 6'd1;
    @(negedge clk); e = cyc; idle();
    wait_cyc(8);
    chk("R5", "ret count", rn, 1);
    chk("R5", "ret tag", r_tag[0], 1);
    chk("R5", "ret data", r_dat[0], pat(16'h10));
    chk("R5", "ret fwd", r_fwd[0], 0);
    chk("R5", "ret delay", r_cyc[0] - e, 3);
    chk("R5", "read req delay", m_cyc[0] - e, 1);
    chk("R5", "read req we", m_we[0], 0);
  endtask

  task automatic t_same_cycle_fwd(); // R3
    int e;
    clear_logs();
    st_enq_valid = 1; st_enq_addr = 16'h0020; st_enq_data = 32'h1111_2222;
    ld_enq_valid = 1; ld_enq_addr = 16'h0020; ld_enq_tag = 6'd2;
    @(negedge clk); e = cyc; idle();
    wait_cyc(6);
    chk("R3", "ret count", rn, 1);
    chk("R3", "fwd data", r_dat[0], 32'h1111_2222);
    chk("R3", "fwd flag", r_fwd[0], 1);
    chk("R3", "fwd delay", r_cyc[0] - e, 1);
    chk("R3", "requests (write only)", mn, 1);
    chk("R3", "request is write", m_we[0], 1);
  endtask

  task automatic t_war_youngest(); // R4 R7 R8
    clear_logs();
    ld_enq_valid = 1; ld_enq_addr = 16'h0040; ld_enq_tag = 6'd3;
    @(negedge clk); idle();
    st_enq_valid = 1; st_enq_addr = 16'h0040; st_enq_data = 32'h0000_00D1;
    @(negedge clk); st_enq_data = 32'h0000_00D2;
    @(negedge clk); idle();
    ld_enq_valid = 1; ld_enq_addr = 16'h0040; ld_enq_tag = 6'd4;
    @(negedge clk); idle();
    wait_cyc(12);
    chk("R7", "ret count", rn, 2);
    chk("R7", "older load sees old value", r_dat[0], pat(16'h40));
    chk("R4", "youngest store forwarded", r_dat[1], 32'h0000_00D2);
    chk("R4", "fwd flag", r_fwd[1], 1);
    chk("R8", "write count", mn, 3);
    chk("R8", "first write data", m_dat[1], 32'h0000_00D1);
    chk("R8", "second write data", m_dat[2], 32'h0000_00D2);
    chk("R8", "writes back to back", m_cyc[2] - m_cyc[1], 1);
    chk("R7", "write after load return", (m_cyc[1] > r_cyc[0]), 1);
    chk("R8", "final memory", mem[8'h40], 32'h0000_00D2);
  endtask

  task automatic t_order(); // R6
    clear_logs();
    ld_enq_valid = 1; ld_enq_addr = 16'h0050; ld_enq_tag = 6'd5;
    @(negedge clk);
    st_enq_valid = 1; st_enq_addr = 16'h0060; st_enq_data = 32'h0000_0066;
    ld_enq_addr = 16'h0060; ld_enq_tag = 6'd6;
    @(negedge clk); st_enq_valid = 0;
    ld_enq_addr = 16'h0070; ld_enq_tag = 6'd7;
    @(negedge clk); idle();
    wait_cyc(14);
    chk("R6", "ret count", rn, 3);
    chk("R6", "order 0", r_tag[0], 5);
    chk("R6", "order 1", r_tag[1], 6);
    chk("R6", "order 2", r_tag[2], 7);
    chk("R6", "data 1 forwarded", r_dat[1], 32'h0000_0066);
    chk("R6", "data 2 memory", r_dat[2], pat(16'h70));
    chk("R6", "fwd flags", {r_fwd[0], r_fwd[1], r_fwd[2]}, 3'b010);
  endtask

  task automatic t_priority(); // R9
    int e;
    clear_logs();
    st_enq_valid = 1; st_enq_addr = 16'h00A0; st_enq_data = 32'h0000_00AA;
    ld_enq_valid = 1; ld_enq_addr = 16'h00B0; ld_enq_tag = 6'd8;
    @(negedge clk); e = cyc; idle();
    wait_cyc(8);
    chk("R9", "request count", mn, 2);
    chk("R9", "first is read", m_we[0], 0);
    chk("R9", "read at", m_cyc[0] - e, 1);
    chk("R9", "second is write", m_we[1], 1);
    chk("R9", "write at", m_cyc[1] - e, 2);
  endtask

  task automatic t_full(); // R2
    int acc_n = 0;
    logic [TW-1:0] acc_tag [32];
    logic saw_full = 0;
    clear_logs();
    for (int k = 0; k < 24; k++) begin
      if (ld_full) saw_full = 1;
      else begin acc_tag[acc_n] = 6'(k + 16); acc_n++; end
      ld_enq_valid = 1; ld_enq_addr = 16'(16'h00C0 + k); ld_enq_tag = 6'(k + 16);
      @(negedge clk);
    end
    idle();
    wait_cyc(60);
    chk("R2", "full seen", saw_full, 1);
    chk("R2", "returns equal accepted", rn, acc_n);
    for (int i = 0; i < acc_n && i < rn; i++)
      chk("R2", "accepted tag returned", r_tag[i], acc_tag[i]);
  endtask

  task automatic t_flush(); // R10
    clear_logs();
    ld_enq_valid = 1; ld_enq_addr = 16'h00E0; ld_enq_tag = 6'd40;
    @(negedge clk); idle();
    st_enq_valid = 1; st_enq_addr = 16'h00E0; st_enq_data = 32'h0000_00EE;
    @(negedge clk); idle(); flush = 1;
    @(negedge clk); flush = 0;
    chk("R10", "ld_full after flush", ld_full, 0);
    chk("R10", "st_full after flush", st_full, 0);
    chk("R10", "mem_req_valid after flush", mem_req_valid, 0);
    chk("R10", "ret_valid after flush", ret_valid, 0);
    wait_cyc(10);
    chk("R10", "no return of flushed load", rn, 0);
    chk("R10", "only the early read", mn, 1);
    chk("R10", "memory untouched", mem[8'hE0], pat(16'hE0));
    clear_logs();
    ld_enq_valid = 1; ld_enq_addr = 16'h00E4; ld_enq_tag = 6'd41;
    @(negedge clk); idle();
    wait_cyc(8);
    chk("R10", "load after flush", r_dat[0], pat(16'hE4));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_mem_load();
    t_same_cycle_fwd();
    t_war_youngest();
    t_order();
    t_priority();
    t_full();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule